// File: doc/BRIEF.md
# Cross-Domain Configuration Register Transfer

This block keeps two configuration registers, a control word and a threshold word, that software writes from a fast processor clock and that a slow converter clock consumes. A processor write is latched into a staging register on the fast side and announced to the slow side by flipping a request toggle. The slow side synchronizes that toggle, copies the staged word into the addressed register and returns an acknowledge toggle, which is synchronized back to the fast side.

A single busy flag, readable by software, is high from the cycle after an accepted write until the acknowledge has come back. While it is high, every write is dropped, whichever register it targets, and the earlier contents stay as they were. Software polls the flag before writing. The two clocks are unrelated, and each side has its own active-low asynchronous reset.

Top module: `cfgsync_top`

## Requirements
- R1: After both resets, `cpu_busy` is 0 and both `slow_ctrl` and `slow_thresh` are zero.
- R2: An accepted write with `cpu_addr` = 0 loads `cpu_wdata` into `slow_ctrl`, and one with `cpu_addr` = 1 loads it into `slow_thresh`. The register that was not addressed keeps its value.
- R3: A write is accepted when `cpu_wr_en` is 1 and `cpu_busy` is 0. `cpu_busy` reads 1 from the first fast-clock edge after an accepted write.
- R4: A write presented while `cpu_busy` is 1 is discarded, whatever its address. Neither slow register is altered by it, and the transfer already in flight completes with its own data.
- R5: The staged address and data do not change while `cpu_busy` stays 1, so the slow side samples a static bus.
- R6: A slow register changes only in the slow cycle that follows a newly seen request, and a single transfer never changes both registers.
- R7: `cpu_busy` returns to 0 only after the new value is visible on the slow outputs. The next write is then accepted.
- R8: Because the request passes a two-stage synchronizer, `cpu_busy` stays 1 for at least two slow-clock periods per transfer. The acknowledge also passes two stages, so the flag clears within eight slow periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Fast processor clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset, fast side |
| cpu_wr_en | input | 1 | Write strobe |
| cpu_addr | input | 1 | Register select: 0 control, 1 threshold |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | Transfer in flight; writes are dropped |
| slow_clk | input | 1 | Slow converter clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow side |
| slow_ctrl | output | DATA_W | Control word in the slow domain |
| slow_thresh | output | DATA_W | Threshold word in the slow domain |

## Verification
Random address and data writes, made only while the block is idle, show that each address reaches its own register and leaves the other one alone. An intruding write a few fast cycles after an accepted one is aimed at the same register or at the other one. This separates a lockout that covers every register from one that only protects the target of the transfer. Directed cases cover writes on the very next cycle, all-ones and all-zeros data, and rewrites of the same value. The busy window is measured in fast cycles and checked against the lower and upper bounds that the two synchronizer paths impose.

// File: rtl/cfgsync_pkg.sv
package cfgsync_pkg;
    parameter int CFG_W       = 8;
    parameter int SYNC_STAGES = 2;

    typedef enum logic {
        SEL_CTRL   = 1'b0,
        SEL_THRESH = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/cfgsync_bit_sync.sv
module cfgsync_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgsync_cpu.sv
module cfgsync_cpu
    import cfgsync_pkg::*;
#(
    parameter int DATA_W      = CFG_W,
    parameter int SYNC_STAGES = cfgsync_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_tgl_async,
    output logic              busy,
    output logic              req_tgl,
    output reg_sel_e          stage_sel,
    output logic [DATA_W-1:0] stage_data
);
    typedef struct packed {
        logic              req;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } cpu_state_t;

    cpu_state_t state_d, state_q;
    logic       ack_s;
    logic       accept;

    cfgsync_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl_async),
        .q     (ack_s)
    );

    assign busy = state_q.req ^ ack_s;

    always_comb begin
        state_d = state_q;
        accept  = wr_en && !busy;
        if (accept) begin
            state_d.req  = ~state_q.req;
            state_d.sel  = addr;
            state_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{req: 1'b0, sel: SEL_CTRL, data: '0};
        else        state_q <= state_d;
    end

    assign req_tgl    = state_q.req;
    assign stage_sel  = state_q.sel;
    assign stage_data = state_q.data;

    // R3: a transfer starts only from an accepted write
    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en) && !$past(busy));

    // R4: a write during busy leaves the request toggle alone
    assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(req_tgl));

    // R5: staged bus is frozen for the whole transfer
    assert_stage_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(stage_data) && $stable(stage_sel)));
endmodule

// File: rtl/cfgsync_slow.sv
module cfgsync_slow
    import cfgsync_pkg::*;
#(
    parameter int DATA_W      = CFG_W,
    parameter int SYNC_STAGES = cfgsync_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_async,
    input  reg_sel_e          stage_sel,
    input  logic [DATA_W-1:0] stage_data,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] thresh
);
    typedef struct packed {
        logic              seen;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] thresh;
    } slow_state_t;

    slow_state_t state_d, state_q;
    logic        req_s;
    logic        pending;

    cfgsync_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl_async),
        .q     (req_s)
    );

    assign pending = req_s ^ state_q.seen;

    always_comb begin
        state_d = state_q;
        if (pending) begin
            state_d.seen = req_s;
            if (stage_sel == SEL_CTRL) state_d.ctrl   = stage_data;
            else                       state_d.thresh = stage_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ack_tgl = state_q.seen;
    assign ctrl    = state_q.ctrl;
    assign thresh  = state_q.thresh;

    // R6: outputs move only after a newly seen request
    assert_update_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctrl) || !$stable(thresh)) |-> $past(pending));

    // R6: one transfer touches one register
    assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(ctrl) && !$stable(thresh)));

    // R2: the control word moves only for a control-addressed transfer
    assert_ctrl_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> ($past(stage_sel) == SEL_CTRL));
endmodule

// File: rtl/cfgsync_top.sv
module cfgsync_top
    import cfgsync_pkg::*;
#(
    parameter int DATA_W      = CFG_W,
    parameter int SYNC_STAGES = cfgsync_pkg::SYNC_STAGES
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_wr_en,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    output logic [DATA_W-1:0] slow_ctrl,
    output logic [DATA_W-1:0] slow_thresh
);
    logic              req_tgl;
    logic              ack_tgl;
    reg_sel_e          stage_sel;
    logic [DATA_W-1:0] stage_data;

    cfgsync_cpu #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_cpu (
        .clk           (cpu_clk),
        .rst_n         (cpu_rst_n),
        .wr_en         (cpu_wr_en),
        .addr          (reg_sel_e'(cpu_addr)),
        .wdata         (cpu_wdata),
        .ack_tgl_async (ack_tgl),
        .busy          (cpu_busy),
        .req_tgl       (req_tgl),
        .stage_sel     (stage_sel),
        .stage_data    (stage_data)
    );

    cfgsync_slow #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slow (
        .clk           (slow_clk),
        .rst_n         (slow_rst_n),
        .req_tgl_async (req_tgl),
        .stage_sel     (stage_sel),
        .stage_data    (stage_data),
        .ack_tgl       (ack_tgl),
        .ctrl          (slow_ctrl),
        .thresh        (slow_thresh)
    );
endmodule

// File: tb/sim_cfgsync_top.sv
`timescale 1ns/1ps
module sim_cfgsync_top;
    localparam int W = 8;
    localparam int SLOW_HALF = 500;
    localparam int RATIO = (2 * SLOW_HALF) / 8;

    logic         cpu_clk = 0, slow_clk = 0;
    logic         cpu_rst_n = 0, slow_rst_n = 0;
    logic         cpu_wr_en = 0, cpu_addr = 0;
    logic [W-1:0] cpu_wdata = '0;
    logic         cpu_busy;
    logic [W-1:0] slow_ctrl, slow_thresh;

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] exp_ctrl = '0, exp_thresh = '0;
    int busy_len;

    always #4 cpu_clk = ~cpu_clk;
    always #(SLOW_HALF) slow_clk = ~slow_clk;

    cfgsync_top #(.DATA_W(W)) u0 (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_wr_en(cpu_wr_en),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .slow_ctrl(slow_ctrl), .slow_thresh(slow_thresh)
    );

    function automatic logic [W-1:0] model_reg(input logic [W-1:0] cur,
            input logic hit, input logic [W-1:0] d);
        return hit ? d : cur;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one-cycle write strobe; returns busy as seen one cycle later
    task automatic pulse_write(input logic a, input logic [W-1:0] d, output logic busy_after);
        @(negedge cpu_clk);
        cpu_wr_en = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_wr_en = 0;
        busy_after = cpu_busy;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 1;
        while (cpu_busy && cycles < 4000) begin
            @(negedge cpu_clk);
            cycles++;
        end
    endtask

    task automatic accepted_write(input logic a, input logic [W-1:0] d,
            input bit intrude, input logic ia, input logic [W-1:0] idat, input int gap);
        logic b;
        pulse_write(a, d, b);
        check("R3 busy after accepted write", b, 1'b1);
        exp_ctrl   = model_reg(exp_ctrl,   a == 1'b0, d);
        exp_thresh = model_reg(exp_thresh, a == 1'b1, d);
        busy_len = 1;
        if (intrude) begin
            for (int k = 0; k < gap; k++) begin
                @(negedge cpu_clk);
                busy_len++;
            end
            pulse_write(ia, idat, b);   // R4: dropped, model untouched
            busy_len++;
        end
        begin
            int c;
            wait_idle(c);
            busy_len += c;
        end
        check("R7 busy cleared", cpu_busy, 1'b0);
        check("R8 busy lower bound", busy_len >= 2 * RATIO, 1'b1);
        check("R8 busy upper bound", busy_len <= 8 * RATIO, 1'b1);
        check("R2/R4 ctrl value", slow_ctrl, exp_ctrl);
        check("R2/R4 thresh value", slow_thresh, exp_thresh);
    endtask

    initial begin
        repeat (190000) @(posedge cpu_clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge slow_clk);
        cpu_rst_n = 1; slow_rst_n = 1;
        @(negedge cpu_clk);
        check("R1 busy after reset", cpu_busy, 1'b0);
        check("R1 ctrl after reset", slow_ctrl, '0);
        check("R1 thresh after reset", slow_thresh, '0);

        // directed corners
        accepted_write(1'b0, 8'hFF, 1'b0, 1'b0, '0, 0);          // R2 ctrl only
        accepted_write(1'b1, 8'hA5, 1'b1, 1'b1, 8'h3C, 0);       // R4 same reg next cycle
        accepted_write(1'b0, 8'h00, 1'b1, 1'b1, 8'h77, 3);       // R4 other reg blocked
        accepted_write(1'b1, 8'hA5, 1'b1, 1'b0, 8'hEE, 20);      // same value rewrite
        accepted_write(1'b1, 8'h00, 1'b0, 1'b0, '0, 0);

        for (int i = 0; i < 30; i++) begin
            logic a, ia;
            logic [W-1:0] d, idat;
            a    = 1'($urandom);
            d    = W'($urandom);
            ia   = 1'($urandom);
            idat = W'($urandom);
            accepted_write(a, d, 1'($urandom), ia, idat, int'($urandom_range(0, 100)));
        end
        finish_run();
    end
endmodule